// File: doc/BRIEF.md
# JTAG Host Shift Sequencer

This block drives a JTAG target from the host side. It turns short commands into the TCK, TMS and TDI pin activity that the target's test access port needs, and reads TDO back. There are three operations: walk the target's TAP to Run-Test/Idle through Test-Logic-Reset, load a 32-bit instruction, and exchange a 32-bit data word. Each operation starts from Run-Test/Idle and ends there again, so operations can be issued one after another without any state tracking outside the block.

A command is accepted on a valid/ready handshake. It carries a 2-bit opcode, a 32-bit word and a half-period divisor that sets the TCK rate for that command. Every TCK cycle has a low phase followed by a high phase. TMS and TDI change only at the start of the low phase, and TDO is sampled on the system clock edge that raises TCK. Words are shifted LSB first, and TMS is raised on the last shifted bit. When the last cycle finishes, a single-cycle response pulse returns the word captured from TDO. A read is an exchange that sends zero, and a write is an exchange whose response is ignored.

The control FSM has three states. `S_IDLE` waits for a command and goes to `S_TCK_LOW` on accept. `S_TCK_LOW` goes to `S_TCK_HIGH` when the phase timer expires. `S_TCK_HIGH` goes back to `S_TCK_LOW` for the next bit when the timer expires, or to `S_IDLE` when the bit just finished was the last one of the operation.

Top module: `jtag_shift_host`

## Requirements
- R1: After reset, and whenever no command is in progress, `cmd_ready_o` is 1 and `tck_o`, `tms_o`, `tdi_o` and `rsp_valid_o` are 0.
- R2: Each TCK cycle holds `tck_o` low for `half_div_i`+1 system clocks and then high for `half_div_i`+1 system clocks. `half_div_i` is sampled when the command is accepted. `tms_o` and `tdi_o` do not change while `tck_o` is high.
- R3: Opcode 2'b00 (and 2'b11, which acts the same) produces 6 TCK cycles with TMS 1,1,1,1,1,0 and returns a response word of 0.
- R4: Opcode 2'b01 (instruction load) produces 38 TCK cycles. TMS is 1,1,0,0, then 0 for 31 shift cycles, 1 on the 32nd shift cycle, then 1, then 0. On shift cycle i (cycle index 4+i), TDI carries bit i of the command word.
- R5: Opcode 2'b10 (data exchange) produces 37 TCK cycles. TMS is 1,0,0, then 0 for 31 shift cycles, 1 on the 32nd shift cycle, then 1, then 0. On shift cycle i (cycle index 3+i), TDI carries bit i of the command word.
- R6: TDI is 0 on every TCK cycle that is not a shift cycle.
- R7: The TDO value sampled at the rising TCK edge of shift cycle i is returned at bit i of `rsp_word_o`, for both instruction loads and data exchanges.
- R8: `cmd_ready_o` falls in the clock after a command is accepted and stays low until the last TCK high phase ends. Command inputs presented in that interval are ignored.
- R9: `rsp_valid_o` is high for exactly one system clock, in the first clock after the last high phase, and `cmd_ready_o` is already 1 in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle and able to accept a command |
| cmd_op_i | input | 2 | Opcode: 00/11 reset walk, 01 instruction load, 10 data exchange |
| cmd_word_i | input | WORD_W | Word to shift out on TDI, LSB first |
| half_div_i | input | DIV_W | TCK half period minus one, in system clocks |
| rsp_valid_o | output | 1 | One-clock pulse at the end of a command |
| rsp_word_o | output | WORD_W | Word captured from TDO |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
The bench acts as the target. It logs TMS and TDI on every rising TCK edge and drives TDO from a fixed 64-bit stream, changing it just after each rising edge. This lets it check the TMS walks bit by bit and check the alignment of the returned word. An off-by-one in the walk length would shift the captured word by one bit, and reversing the shift direction would reverse it, so both show up in the response. Divisors of 0 to 3 are used, and the total time TCK spends high and low is measured; a divider that loads once instead of per phase, or is short by one clock, gives the wrong totals. A command held valid with different contents while the sequencer is busy would show up as altered TDI bits, as a second response, or as extra TCK edges if the design accepted it.

// File: rtl/jtag_seq_pkg.sv
package jtag_seq_pkg;

    typedef enum logic [1:0] {
        OP_RESET     = 2'b00,
        OP_IR_LOAD   = 2'b01,
        OP_DR_XCHG   = 2'b10,
        OP_RESET_ALT = 2'b11
    } jtag_op_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'b00,
        S_TCK_LOW  = 2'b01,
        S_TCK_HIGH = 2'b10
    } seq_state_e;

    localparam int RESET_ONES = 5;
    localparam int IR_LEAD    = 4;
    localparam int DR_LEAD    = 3;

endpackage

// File: rtl/jtag_half_timer.sv
module jtag_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             expire_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start_i)       cnt_q <= div_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/jtag_walk_decode.sv
module jtag_walk_decode
    import jtag_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 6
) (
    input  jtag_op_e          op_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              tms_o,
    output logic              tdi_o,
    output logic              shift_o,
    output logic              last_o
);
    localparam int POS_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [IDX_W-1:0] lead;
    logic [IDX_W-1:0] sh_end;
    logic [IDX_W-1:0] pos;
    logic             is_ir;

    always_comb begin
        is_ir   = (op_i == OP_IR_LOAD);
        lead    = is_ir ? IDX_W'(IR_LEAD) : IDX_W'(DR_LEAD);
        sh_end  = lead + IDX_W'(WORD_W);
        pos     = idx_i - lead;
        tms_o   = 1'b0;
        tdi_o   = 1'b0;
        shift_o = 1'b0;
        last_o  = 1'b0;
        unique case (op_i)
            OP_RESET, OP_RESET_ALT: begin
                tms_o  = (idx_i < IDX_W'(RESET_ONES));
                last_o = (idx_i == IDX_W'(RESET_ONES));
            end
            OP_IR_LOAD, OP_DR_XCHG: begin
                if (idx_i < lead) begin
                    tms_o = is_ir ? (idx_i < IDX_W'(2)) : (idx_i == '0);
                end else if (idx_i < sh_end) begin
                    shift_o = 1'b1;
                    tms_o   = (idx_i == sh_end - IDX_W'(1));
                    tdi_o   = word_i[pos[POS_W-1:0]];
                end else if (idx_i == sh_end) begin
                    tms_o = 1'b1;
                end else begin
                    last_o = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/jtag_tdo_capture.sv
module jtag_tdo_capture #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) word_o <= '0;
        else if (en_i)       word_o <= {bit_i, word_o[WORD_W-1:1]};
    end
endmodule

// File: rtl/jtag_shift_host.sv
module jtag_shift_host
    import jtag_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [1:0]        cmd_op_i,
    input  logic [WORD_W-1:0] cmd_word_i,
    input  logic [DIV_W-1:0]  half_div_i,
    output logic              rsp_valid_o,
    output logic [WORD_W-1:0] rsp_word_o,
    output logic              tck_o,
    output logic              tms_o,
    output logic              tdi_o,
    input  logic              tdo_i
);
    localparam int IDX_W = $clog2(WORD_W + IR_LEAD + 2);

    seq_state_e        state_q, state_d;
    jtag_op_e          op_q, nxt_op;
    logic [WORD_W-1:0] word_q, nxt_word;
    logic [DIV_W-1:0]  div_q, tmr_div;
    logic [IDX_W-1:0]  idx_q, nxt_idx;
    logic              accept, expire, tmr_start;
    logic              cur_shift, cur_last, cur_tms_unused, cur_tdi_unused;
    logic              nxt_tms, nxt_tdi, nxt_shift_unused, nxt_last_unused;

    assign cmd_ready_o = (state_q == S_IDLE);
    assign accept      = cmd_valid_i && cmd_ready_o;
    assign nxt_op      = accept ? jtag_op_e'(cmd_op_i) : op_q;
    assign nxt_word    = accept ? cmd_word_i : word_q;
    assign nxt_idx     = accept ? '0 : idx_q + IDX_W'(1);
    assign tmr_div     = accept ? half_div_i : div_q;
    assign tmr_start   = accept
                       || (state_q == S_TCK_LOW && expire)
                       || (state_q == S_TCK_HIGH && expire && !cur_last);

    jtag_half_timer #(.DIV_W(DIV_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .start_i(tmr_start),
        .div_i(tmr_div), .expire_o(expire)
    );

    jtag_walk_decode #(.WORD_W(WORD_W), .IDX_W(IDX_W)) dec_cur_i (
        .op_i(op_q), .idx_i(idx_q), .word_i(word_q),
        .tms_o(cur_tms_unused), .tdi_o(cur_tdi_unused),
        .shift_o(cur_shift), .last_o(cur_last)
    );

    jtag_walk_decode #(.WORD_W(WORD_W), .IDX_W(IDX_W)) dec_nxt_i (
        .op_i(nxt_op), .idx_i(nxt_idx), .word_i(nxt_word),
        .tms_o(nxt_tms), .tdi_o(nxt_tdi),
        .shift_o(nxt_shift_unused), .last_o(nxt_last_unused)
    );

    jtag_tdo_capture #(.WORD_W(WORD_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .clr_i(accept),
        .en_i(state_q == S_TCK_LOW && expire && cur_shift),
        .bit_i(tdo_i), .word_o(rsp_word_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (accept) state_d = S_TCK_LOW;
            S_TCK_LOW:  if (expire) state_d = S_TCK_HIGH;
            S_TCK_HIGH: if (expire) state_d = cur_last ? S_IDLE : S_TCK_LOW;
            default:    state_d = S_IDLE;
        endcase
    end

    // Registered outputs and command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= OP_RESET;
            word_q      <= '0;
            div_q       <= '0;
            idx_q       <= '0;
            tck_o       <= 1'b0;
            tms_o       <= 1'b0;
            tdi_o       <= 1'b0;
            rsp_valid_o <= 1'b0;
        end else begin
            rsp_valid_o <= 1'b0;
            unique case (state_q)
                S_IDLE: if (accept) begin
                    op_q   <= nxt_op;
                    word_q <= nxt_word;
                    div_q  <= half_div_i;
                    idx_q  <= '0;
                    tck_o  <= 1'b0;
                    tms_o  <= nxt_tms;
                    tdi_o  <= nxt_tdi;
                end
                S_TCK_LOW: if (expire) tck_o <= 1'b1;
                S_TCK_HIGH: if (expire) begin
                    tck_o <= 1'b0;
                    if (cur_last) begin
                        tms_o       <= 1'b0;
                        tdi_o       <= 1'b0;
                        rsp_valid_o <= 1'b1;
                    end else begin
                        idx_q <= nxt_idx;
                        tms_o <= nxt_tms;
                        tdi_o <= nxt_tdi;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: TCK rests low while idle
    p_tck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> !tck_o);
    // R2: pins frozen during the high phase
    p_pins_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));
    // R8: ready drops after accept
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_ready_o);
    // R9: response is a single pulse
    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);
    // R9: response arrives with ready already high
    p_rsp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> cmd_ready_o);
endmodule

// File: tb/jtag_shift_host_tb_top.sv
module jtag_shift_host_tb_top;
    localparam int WORD_W = 32;
    localparam int DIV_W  = 8;
    localparam logic [63:0] STREAM = 64'hA5C3_1E97_5B2D_8F46;
    localparam int NVEC = 6;
    localparam logic [1:0]  V_OP   [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b10, 2'b01, 2'b11};
    localparam logic [31:0] V_WORD [NVEC] = '{32'h0, 32'hFFFF_FFFE, 32'h0,
                                             32'h8000_0001, 32'h1234_5678, 32'hDEAD_BEEF};
    localparam logic [7:0]  V_DIV  [NVEC] = '{8'd1, 8'd0, 8'd2, 8'd1, 8'd3, 8'd0};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, rsp_valid, tck, tms, tdi, tdo = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [WORD_W-1:0] cmd_word = '0, rsp_word;
    logic [DIV_W-1:0] half_div = '0;

    int n_checks = 0, n_fail = 0;
    int edge_cnt = 0, hi_clk = 0, lo_clk = 0, rsp_cnt = 0;
    logic [31:0] rsp_seen = '0;
    logic tms_log [0:63];
    logic tdi_log [0:63];
    bit done = 1'b0;

    always #10 clk = ~clk;

    jtag_shift_host #(.WORD_W(WORD_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_op_i(cmd_op), .cmd_word_i(cmd_word), .half_div_i(half_div),
        .rsp_valid_o(rsp_valid), .rsp_word_o(rsp_word),
        .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo)
    );

    // Target model: log pins at rising TCK, advance TDO just after it
    always @(posedge tck) begin
        if (edge_cnt < 64) begin
            tms_log[edge_cnt] = tms;
            tdi_log[edge_cnt] = tdi;
        end
        edge_cnt = edge_cnt + 1;
        tdo = STREAM[edge_cnt % 64];
    end

    always @(negedge clk) begin
        if (!cmd_ready && tck)  hi_clk++;
        if (!cmd_ready && !tck) lo_clk++;
        if (rsp_valid) begin
            rsp_cnt++;
            rsp_seen = rsp_word;
            chk(cmd_ready == 1'b1, "R9", "ready with response", 64'(cmd_ready), 64'd1);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [1:0] op);
        return (op == 2'b01) ? 38 : (op == 2'b10) ? 37 : 6;
    endfunction

    function automatic int exp_lead(input logic [1:0] op);
        return (op == 2'b01) ? 4 : 3;
    endfunction

    function automatic bit exp_tms(input logic [1:0] op, input int i);
        int ld;
        if (op == 2'b00 || op == 2'b11) return (i < 5);
        ld = exp_lead(op);
        if (i < ld) return (op == 2'b01) ? (i < 2) : (i == 0);
        if (i < ld + 32) return (i == ld + 31);
        return (i == ld + 32);
    endfunction

    function automatic bit exp_tdi(input logic [1:0] op, input logic [31:0] w, input int i);
        int ld;
        if (op == 2'b00 || op == 2'b11) return 1'b0;
        ld = exp_lead(op);
        if (i >= ld && i < ld + 32) return w[i - ld];
        return 1'b0;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input logic [31:0] w,
                           input logic [7:0] dv, input int noise, input string tag);
        int n, tms_bad, tdi_bad, first_bad;
        logic ready_after;
        logic [31:0] exp_rsp;
        @(negedge clk);
        edge_cnt = 0; hi_clk = 0; lo_clk = 0; rsp_cnt = 0;
        tdo = STREAM[0];
        cmd_op = op; cmd_word = w; half_div = dv; cmd_valid = 1'b1;
        @(negedge clk);
        ready_after = cmd_ready;
        if (noise > 0) begin
            cmd_op = 2'b01; cmd_word = ~w; half_div = 8'd7;
            repeat (noise) @(negedge clk);
        end
        cmd_valid = 1'b0;
        for (int t = 0; t < 4000 && rsp_cnt == 0; t++) @(posedge clk);
        repeat (2) @(negedge clk);

        n = exp_len(op);
        tms_bad = 0; tdi_bad = 0; first_bad = -1;
        for (int i = 0; i < n && i < 64; i++) begin
            if (tms_log[i] !== exp_tms(op, i)) begin
                tms_bad++;
                if (first_bad < 0) first_bad = i;
            end
            if (tdi_log[i] !== exp_tdi(op, w, i)) tdi_bad++;
        end
        exp_rsp = (op == 2'b00 || op == 2'b11) ? 32'h0 : 32'(STREAM >> exp_lead(op));

        chk(ready_after == 1'b0, "R8", {tag, " ready after accept"}, 64'(ready_after), 64'd0);
        chk(edge_cnt == n, (op == 2'b01) ? "R4" : (op == 2'b10) ? "R5" : "R3",
            {tag, " TCK cycle count"}, edge_cnt, n);
        chk(tms_bad == 0, (op == 2'b01) ? "R4" : (op == 2'b10) ? "R5" : "R3",
            {tag, " TMS mismatches (first index)"}, first_bad, -1);
        chk(tdi_bad == 0, "R6", {tag, " TDI mismatches"}, tdi_bad, 0);
        chk(rsp_seen == exp_rsp, "R7", {tag, " response word"}, rsp_seen, exp_rsp);
        chk(rsp_cnt == 1, "R9", {tag, " response pulses"}, rsp_cnt, 1);
        chk(hi_clk == n * (dv + 1), "R2", {tag, " TCK high clocks"}, hi_clk, n * (dv + 1));
        chk(lo_clk == n * (dv + 1), "R2", {tag, " TCK low clocks"}, lo_clk, n * (dv + 1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready == 1'b1, "R1", "ready in reset", 64'(cmd_ready), 64'd1);
        chk({tck, tms, tdi, rsp_valid} == 4'b0, "R1", "pins in reset",
            64'({tck, tms, tdi, rsp_valid}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({cmd_ready, tck, tms, tdi} == 4'b1000, "R1", "idle after reset",
            64'({cmd_ready, tck, tms, tdi}), 64'h8);

        for (int v = 0; v < NVEC; v++)
            run_cmd(V_OP[v], V_WORD[v], V_DIV[v], 0, $sformatf("vec%0d", v));

        // R8: command inputs held valid with other contents while busy are ignored
        run_cmd(2'b10, 32'h0F0F_00FF, 8'd0, 20, "busy_noise");
        repeat (10) @(negedge clk);
        chk(edge_cnt == 37 && cmd_ready, "R8", "no extra command after noise",
            edge_cnt, 37);

        // R1: pins return to rest after a command
        chk({tck, tms, tdi, rsp_valid} == 4'b0, "R1", "pins idle after command",
            64'({tck, tms, tdi, rsp_valid}), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule